// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked user port perform single-word reads and writes on an external asynchronous static RAM. The RAM has a 20-bit address, a 4-bit data path and three active-low strobes: chip select, output enable and write enable. The controller holds each strobe for a whole number of system clock cycles. Each count is derived at elaboration time from a nanosecond minimum and the clock period, using ceil(t / period), with a floor of one cycle.

A request is presented with a valid/ready handshake that carries an address, write data and a write flag. A read keeps chip select and output enable low until the access time has elapsed. The data is then captured into a register, and a one-cycle response pulse returns it. The controller then waits out the memory's release time with all strobes high before it accepts more work. A write first drives the address and data, then pulses write enable while output enable stays high, and then releases the bus. The data bus is split into an input, an output and an explicit drive-enable, so pad buffers can be placed outside the block.

Top module: `sram_ctl`

## Requirements
- R1: After reset, all three strobes are high (1), the bus drive-enable is low, req_ready is high and rsp_valid is low.
- R2: A read holds chip select and output enable low, with write enable high, for RD_CYC cycles (3 at the default 4 ns period with 12 ns access and cycle time). rsp_valid is high for exactly one cycle, starting on the third clock edge after the accepting edge, and rsp_rdata then carries the data the memory presented at the end of the access.
- R3: After a read, all strobes stay high and the bus stays undriven for TURN_CYC cycles (2 for a 6 ns release time). A read therefore keeps req_ready low for 5 cycles after the accepting edge.
- R4: During a write, write enable is low for WP_CYC cycles (2 for an 8 ns pulse and 6 ns data setup) while chip select is low and output enable is high. The bus drive-enable is high and the write data is stable for the whole pulse.
- R5: mem_addr changes only on an accepting edge. It never changes while chip select and write enable are both low.
- R6: A write keeps req_ready low for 4 cycles after the accepting edge, and a later read of the same address returns the written value.
- R7: req_ready is high only when the controller is idle. A request is taken only on an edge where req_valid and req_ready are both high, and a request held while the controller is busy is taken exactly once.
- R8: The controller never drives the bus while output enable is low. It starts driving only after the memory output has had its release time since the last read.
- R9: At the configured clock period, every strobe interval meets its nanosecond minimum: a 12 ns access, an 8 ns write pulse and a 6 ns bus release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 4 | Write data |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_rdata | output | 4 | Captured read data |
| mem_addr | output | 20 | Address to memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | 4 | Data driven to the bus |
| mem_dq_oe | output | 1 | Bus drive-enable for mem_dq_out |
| mem_dq_in | input | 4 | Data sampled from the bus |

## Verification
An error in the sequencer state or the timer shows up at the ports within one access. A shortened read captures data the memory has not yet settled, so rsp_rdata is wrong three cycles after acceptance. A shortened write pulse leaves the memory unchanged, which is only seen when the same address is read back a few cycles later. A skipped turnaround raises the drive-enable while the memory output is still active, within two cycles of output enable rising. A bad ready or response pulse is off by at least one cycle from the reference at the first request after the fault.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_RD_TURN,
        ST_WR_SET,
        ST_WR_PULSE,
        ST_WR_REC
    } seq_state_e;

    typedef struct packed {
        logic cs_n;
        logic oe_n;
        logic we_n;
        logic dq_oe;
    } strobe_t;

    localparam strobe_t STRB_IDLE = '{cs_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};

    function automatic int cycles_for(input int t_ps, input int clk_ps);
        if (t_ps <= 0) return 0;
        return (t_ps + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic strobe_t strobes_for(input seq_state_e s);
        strobe_t r;
        r = STRB_IDLE;
        case (s)
            ST_RD_ACC: begin
                r.cs_n = 1'b0;
                r.oe_n = 1'b0;
            end
            ST_WR_SET: begin
                r.cs_n  = 1'b0;
                r.dq_oe = 1'b1;
            end
            ST_WR_PULSE: begin
                r.cs_n  = 1'b0;
                r.we_n  = 1'b0;
                r.dq_oe = 1'b1;
            end
            default: r = STRB_IDLE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
    import sram_ctl_pkg::*;
#(
    parameter int CNT_W    = 3,
    parameter int RD_CYC   = 3,
    parameter int TURN_CYC = 2,
    parameter int SET_CYC  = 1,
    parameter int WP_CYC   = 2,
    parameter int REC_CYC  = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             tmr_expired,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             accept,
    output logic             capture,
    output logic             req_ready,
    output strobe_t          strb
);
    seq_state_e state_q, state_d;

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        capture  = 1'b0;
        accept   = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept   = 1'b1;
                    tmr_load = 1'b1;
                    if (req_write) begin
                        state_d = ST_WR_SET;
                        tmr_val = CNT_W'(SET_CYC - 1);
                    end else begin
                        state_d = ST_RD_ACC;
                        tmr_val = CNT_W'(RD_CYC - 1);
                    end
                end
            end
            ST_RD_ACC: begin
                if (tmr_expired) begin
                    capture  = 1'b1;
                    state_d  = ST_RD_TURN;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(TURN_CYC - 1);
                end
            end
            ST_RD_TURN: begin
                if (tmr_expired) state_d = ST_IDLE;
            end
            ST_WR_SET: begin
                if (tmr_expired) begin
                    state_d  = ST_WR_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(WP_CYC - 1);
                end
            end
            ST_WR_PULSE: begin
                if (tmr_expired) begin
                    state_d  = ST_WR_REC;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(REC_CYC - 1);
                end
            end
            ST_WR_REC: begin
                if (tmr_expired) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            strb    <= STRB_IDLE;
        end else begin
            state_q <= state_d;
            strb    <= strobes_for(state_d);
        end
    end

    assign req_ready = (state_q == ST_IDLE);
endmodule

// File: rtl/sram_ctl_dpath.sv
module sram_ctl_dpath #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q    <= '0;
            wdata_q   <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= capture;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (capture) rsp_rdata <= mem_dq_in;
        end
    end
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int DATA_W    = 4,
    parameter int CLK_PS    = 4000,
    parameter int T_RC_PS   = 12000,
    parameter int T_AA_PS   = 12000,
    parameter int T_OE_PS   = 6000,
    parameter int T_HZ_PS   = 6000,
    parameter int T_WC_PS   = 12000,
    parameter int T_WP_PS   = 8000,
    parameter int T_AW_PS   = 8000,
    parameter int T_DW_PS   = 6000,
    parameter int T_AS_PS   = 0,
    parameter int T_WR_PS   = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int RD_CYC   = max2(1, max2(max2(cycles_for(T_AA_PS, CLK_PS),
                                                cycles_for(T_RC_PS, CLK_PS)),
                                           cycles_for(T_OE_PS, CLK_PS)));
    localparam int TURN_CYC = max2(1, cycles_for(T_HZ_PS, CLK_PS));
    localparam int SET_CYC  = max2(1, cycles_for(T_AS_PS, CLK_PS));
    localparam int WP_CYC   = max2(1, max2(max2(cycles_for(T_WP_PS, CLK_PS),
                                                cycles_for(T_DW_PS, CLK_PS)),
                                           cycles_for(T_AW_PS, CLK_PS) - SET_CYC));
    localparam int REC_CYC  = max2(max2(1, cycles_for(T_WR_PS, CLK_PS)),
                                   cycles_for(T_WC_PS, CLK_PS) - SET_CYC - WP_CYC);
    localparam int MAX_CYC  = max2(max2(RD_CYC, TURN_CYC),
                                   max2(max2(SET_CYC, WP_CYC), REC_CYC));
    localparam int CNT_W    = max2(1, $clog2(MAX_CYC + 1));

    logic             tmr_load, tmr_expired, accept, capture;
    logic [CNT_W-1:0] tmr_val;
    strobe_t          strb;
    logic [DATA_W-1:0] wdata_q;

    sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_ctl_seq #(
        .CNT_W    (CNT_W),
        .RD_CYC   (RD_CYC),
        .TURN_CYC (TURN_CYC),
        .SET_CYC  (SET_CYC),
        .WP_CYC   (WP_CYC),
        .REC_CYC  (REC_CYC)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .accept      (accept),
        .capture     (capture),
        .req_ready   (req_ready),
        .strb        (strb)
    );

    sram_ctl_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .capture   (capture),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .mem_dq_in (mem_dq_in),
        .addr_q    (mem_addr),
        .wdata_q   (wdata_q),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    assign mem_cs_n   = strb.cs_n;
    assign mem_oe_n   = strb.oe_n;
    assign mem_we_n   = strb.we_n;
    assign mem_dq_oe  = strb.dq_oe;
    assign mem_dq_out = wdata_q;
endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int CLK_PS  = 4000,
    parameter int T_HZ_PS = 6000
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_dq_oe
);
    localparam int TURN_CYC = max2(1, cycles_for(T_HZ_PS, CLK_PS));
    localparam int HZ_MAX   = TURN_CYC + 1;

    int hz_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hz_cnt <= HZ_MAX;
        end else if (!mem_cs_n && !mem_oe_n) begin
            hz_cnt <= 0;
        end else if (hz_cnt < HZ_MAX) begin
            hz_cnt <= hz_cnt + 1;
        end
    end

    // R8
    drive_oe_high_chk: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> mem_oe_n);

    // R8
    turnaround_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_dq_oe) |-> (hz_cnt >= TURN_CYC));

    // R4
    write_pulse_shape_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (mem_oe_n && mem_dq_oe && !mem_cs_n));

    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && !mem_we_n) |=> (mem_cs_n || mem_we_n || $stable(mem_addr)));

    // R7
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_cs_n |-> !req_ready);

    // R2
    rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);
endmodule

bind sram_ctl sram_ctl_chk #(
    .ADDR_W  (ADDR_W),
    .CLK_PS  (CLK_PS),
    .T_HZ_PS (T_HZ_PS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_ctl_test.sv
`timescale 1ns/1ps
module sram_ctl_test;
    localparam int CLK_NS = 4;
    localparam int TACC_NS = 12;
    localparam int TWP_NS = 8;
    localparam int THZ_NS = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [3:0]  req_wdata = '0;
    logic        req_ready, rsp_valid, mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [3:0]  rsp_rdata, mem_dq_out;
    logic [3:0]  mem_dq_in = 4'h0;
    logic [19:0] mem_addr;

    int checks = 0, failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sram_ctl uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Behavioural memory contents and reference shadow
    logic [3:0] model_mem [int];
    logic [3:0] ref_mem [int];

    function automatic logic [3:0] look(ref logic [3:0] m [int], input int a);
        return m.exists(a) ? m[a] : 4'h0;
    endfunction

    // Reference of the handshake timing
    int   rbusy = 0;
    bit   rrd = 0, acc = 0;
    logic [3:0] rexp = '0;

    always @(posedge clk) begin
        if (rst) begin
            rbusy <= 0; acc <= 0; rrd <= 0;
        end else begin
            acc <= 0;
            if (rbusy > 0) rbusy <= rbusy - 1;
            else if (req_valid) begin
                acc   <= 1;
                rbusy <= req_write ? 4 : 5;
                rrd   <= !req_write;
                if (req_write) ref_mem[int'(req_addr)] = req_wdata;
                else rexp <= look(ref_mem, int'(req_addr));
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(req_ready == (rbusy == 0), "R7", "req_ready", req_ready, rbusy == 0);
            if (rrd) begin
                chk(rsp_valid == (rbusy == 2), "R2", "rsp_valid", rsp_valid, rbusy == 2);
                if (rsp_valid && rbusy == 2)
                    chk(rsp_rdata == rexp, "R6", "read data", rsp_rdata, rexp);
            end else begin
                chk(!rsp_valid, "R2", "rsp_valid on write", rsp_valid, 0);
            end
        end
    end

    // Behavioural SRAM with timing-violation checks
    int   rd_age = 0, wr_age = 0, hz_age = 100;
    bit   wr_prev = 0, wr_data_ok = 1;
    logic [19:0] last_addr = '0, wr_addr = '0;
    logic [3:0]  wr_data = '0;

    always @(negedge clk) begin
        bit reading, writing;
        if (!rst) begin
            reading = !mem_cs_n && !mem_oe_n && mem_we_n;
            writing = !mem_cs_n && !mem_we_n;
            if (reading) rd_age = (mem_addr == last_addr && rd_age > 0) ? rd_age + 1 : 1;
            else rd_age = 0;
            last_addr = mem_addr;
            mem_dq_in <= (rd_age * CLK_NS >= TACC_NS) ? look(model_mem, int'(mem_addr))
                                                     : ~look(model_mem, int'(mem_addr));
            if (reading) hz_age = 0; else if (hz_age < 100) hz_age++;
            if (mem_dq_oe)
                chk(!reading && (hz_age - 1) * CLK_NS >= THZ_NS, "R8",
                    "bus driven during or too soon after memory output", hz_age, 3);
            if (writing) begin
                chk(mem_oe_n == 1'b1, "R4", "oe_n during write", mem_oe_n, 1);
                if (wr_prev) begin
                    if (mem_addr != wr_addr || mem_dq_out != wr_data) wr_data_ok = 0;
                    wr_age++;
                end else begin
                    wr_age = 1; wr_data_ok = mem_dq_oe;
                end
                wr_addr = mem_addr; wr_data = mem_dq_out;
            end else if (wr_prev) begin
                chk(wr_age * CLK_NS >= TWP_NS, "R9", "write pulse width ns",
                    wr_age * CLK_NS, TWP_NS);
                chk(wr_data_ok, "R5", "addr/data stable during write", wr_data_ok, 1);
                if (wr_age * CLK_NS >= TWP_NS && wr_data_ok)
                    model_mem[int'(wr_addr)] = wr_data;
            end
            wr_prev = writing;
        end
    end

    task automatic access(input bit wr, input logic [19:0] a, input logic [3:0] d);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        do @(negedge clk); while (!acc);
        req_valid = 0;
        req_addr = ~a;
        req_wdata = ~d;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: idle state after reset
        chk(mem_cs_n && mem_oe_n && mem_we_n, "R1", "strobes idle",
            {mem_cs_n, mem_oe_n, mem_we_n}, 3'b111);
        chk(!mem_dq_oe, "R1", "bus released", mem_dq_oe, 0);
        chk(req_ready && !rsp_valid, "R1", "ready/rsp", {req_ready, rsp_valid}, 2'b10);

        // R6 R2: write then read back, boundary addresses
        access(1, 20'h00000, 4'h5);
        access(1, 20'hFFFFF, 4'hA);
        access(0, 20'h00000, 4'h0);
        access(0, 20'hFFFFF, 4'h0);
        // R3 R8: read followed at once by a write (turnaround), then overwrite
        access(0, 20'h12345, 4'h0);
        access(1, 20'h12345, 4'hC);
        access(1, 20'h12345, 4'h3);
        access(0, 20'h12345, 4'h0);
        // R7: requests with idle gaps
        repeat (5) @(negedge clk);
        access(0, 20'hFFFFF, 4'h0);
        repeat (2) @(negedge clk);
        access(1, 20'h00001, 4'hF);
        access(0, 20'h00001, 4'h0);
        // Mixed traffic over a small address window
        for (int i = 0; i < 300; i++) begin
            logic [19:0] a;
            a = 20'($urandom_range(0, 15)) ^ (i[0] ? 20'hFFFF0 : 20'h0);
            access(($urandom_range(0, 1) == 1), a, 4'($urandom));
        end
        repeat (8) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * CLK_NS);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule